// File: doc/BRIEF.md
# Recompute-on-Encoded-Operands Logic Checker

This block wraps one bit-sliced logic unit that applies AND, OR or XOR to two operands and checks that unit for permanent faults. It uses the same unit twice in time. In the first pass it works on the raw operands and keeps the answer. In the second pass it encodes both operands and runs them through the same hardware again. It then decodes that answer and compares it with the kept one. A faulty slice usually handles different data in the two passes, so a stuck bit shows up as a mismatch. The two encodings are complementation and a left shift of one or two positions.

A one-cycle start pulse captures the operands, the operation and the encoding. After a fixed sequence of states, a one-cycle done pulse presents the first-pass result and the error flag. A test-only input can force any one slice of the unit to a constant, so that permanent faults can be injected in a controlled way. The unit is two bits wider than the operands, so a shifted operand loses no bits.

Top module: `tr_recompute_checker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, done, error and result are all 0.
- R2: A start sampled high in the idle state begins a run. done is high for exactly one cycle, after the third rising edge that follows the edge that sampled start. It is low in every other cycle.
- R3: opSel selects the operation: 00 is AND, 01 is OR, 10 is XOR, and 11 is also AND. result carries the first-pass output of the unit on the captured operands.
- R4: encMode selects the second-pass encoding: 00 and 11 complement both operands, 01 shifts them left by one bit, and 10 shifts them left by two bits. With no fault injected, error is 0 at done for every operation, mode and operand pair.
- R5: While faultEn is high, slice faultSlice of the unit (0 to WIDTH+1, where 0 is the least significant) outputs faultVal in both passes. result shows the faulty first-pass value. A slice index above WIDTH+1 injects nothing.
- R6: error at done equals the inequality of the first-pass result and the decoded second-pass result. In complement mode the unit runs OR for AND and AND for OR, both on inverted operands, and the low WIDTH bits are inverted back. XOR runs as XOR on inverted operands and is not inverted back. In shift mode the operands are zero-extended to WIDTH+2 bits and shifted left by k, the same operation is applied, and unit bits k to k+WIDTH-1 form the decoded result.
- R7: In complement mode with AND or OR, a stuck slice below WIDTH always raises error, whatever the operands.
- R8: While a run is in progress, start and changes to opA, opB, opSel and encMode are ignored. The run completes with the values captured at its start, and only one done pulse is produced.
- R9: error and result keep their values after done until the next start. A new start clears error in the cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when sampled high in idle |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| opSel | input | 2 | Operation select |
| encMode | input | 2 | Second-pass encoding select |
| faultEn | input | 1 | Enables stuck-at injection (test only) |
| faultSlice | input | $clog2(WIDTH+2) | Index of the slice to force |
| faultVal | input | 1 | Constant the forced slice outputs |
| done | output | 1 | One-cycle completion pulse |
| result | output | WIDTH | First-pass result |
| error | output | 1 | Mismatch between the passes, held until the next start |

## Verification
The assertion that a clean run ends with error low assumes one thing about the fault inputs: faultEn must be low in both pass cycles, not merely at done. The block tracks this itself with a per-run flag. The other properties assume only that start is a synchronous input. The stimulus changes the fault controls only between runs. The single exception is the busy-start test, which changes the operands and the operation, but not the fault controls, while a run is in progress. Fault cases cover every slice, both stuck values, every operation and every mode. Expected flags come from a behavioural model of a unit with one stuck slice.

// File: rtl/tr_pkg.sv
package tr_pkg;

  // Unit function codes after normalisation
  localparam logic [1:0] FN_AND = 2'b00;
  localparam logic [1:0] FN_OR  = 2'b01;
  localparam logic [1:0] FN_XOR = 2'b10;

  // Extra unit slices so a shifted operand keeps all its bits
  localparam int SHIFT_SPAN = 2;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PASS0 = 3'd1,
    ST_PASS1 = 3'd2,
    ST_CMP   = 3'd3,
    ST_DONE  = 3'd4
  } state_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadOps;     // capture operands, clear error
    logic encPass;     // drive unit with encoded operands
    logic storeFirst;  // keep first-pass result
    logic storeSecond; // keep decoded second-pass result
    logic evalCmp;     // compare and update error
  } strobe_t;

endpackage

// File: rtl/tr_logic_unit.sv
module tr_logic_unit #(
  parameter int UW  = 10,
  parameter int SLW = 4
) (
  input  logic [UW-1:0]  inA,
  input  logic [UW-1:0]  inB,
  input  logic [1:0]     fn,
  input  logic           faultEn,
  input  logic [SLW-1:0] faultSlice,
  input  logic           faultVal,
  output logic [UW-1:0]  y
);
  import tr_pkg::*;

  // One slice per bit; the stuck-at override sits at the slice output
  for (genvar i = 0; i < UW; i++) begin : g_slice
    logic raw;
    always_comb begin
      case (fn)
        FN_OR:   raw = inA[i] | inB[i];
        FN_XOR:  raw = inA[i] ^ inB[i];
        default: raw = inA[i] & inB[i];
      endcase
      if (faultEn && (faultSlice == SLW'(i))) y[i] = faultVal;
      else                                    y[i] = raw;
    end
  end

endmodule

// File: rtl/tr_datapath.sv
module tr_datapath #(
  parameter int WIDTH = 8,
  parameter int SLW   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  tr_pkg::strobe_t  stb,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [1:0]       opSel,
  input  logic [1:0]       encMode,
  input  logic             faultEn,
  input  logic [SLW-1:0]   faultSlice,
  input  logic             faultVal,
  output logic [WIDTH-1:0] result,
  output logic             error
);
  import tr_pkg::*;

  localparam int UW = WIDTH + SHIFT_SPAN;

  logic [WIDTH-1:0] aReg, bReg;
  logic [1:0]       fnReg, modeReg;
  logic [WIDTH-1:0] firstRes, secondRes;
  logic             errFlag;

  logic [UW-1:0]    unitA, unitB, unitY;
  logic [1:0]       unitFn;
  logic [WIDTH-1:0] decoded;

  // Normalise codes at capture: op 11 -> AND, mode 11 -> complement
  logic [1:0] opNorm, modeNorm;
  assign opNorm   = (opSel == 2'b11) ? FN_AND : opSel;
  assign modeNorm = (encMode == 2'b11) ? 2'b00 : encMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg    <= '0;
      bReg    <= '0;
      fnReg   <= FN_AND;
      modeReg <= 2'b00;
    end else if (stb.loadOps) begin
      aReg    <= opA;
      bReg    <= opB;
      fnReg   <= opNorm;
      modeReg <= modeNorm;
    end
  end

  // Encoder: selects raw or encoded operands and the unit function
  always_comb begin
    unitA  = {{SHIFT_SPAN{1'b0}}, aReg};
    unitB  = {{SHIFT_SPAN{1'b0}}, bReg};
    unitFn = fnReg;
    if (stb.encPass) begin
      case (modeReg)
        2'b01: begin
          unitA = {1'b0, aReg, 1'b0};
          unitB = {1'b0, bReg, 1'b0};
        end
        2'b10: begin
          unitA = {aReg, 2'b00};
          unitB = {bReg, 2'b00};
        end
        default: begin
          unitA = {{SHIFT_SPAN{1'b1}}, ~aReg};
          unitB = {{SHIFT_SPAN{1'b1}}, ~bReg};
          case (fnReg)
            FN_AND:  unitFn = FN_OR;
            FN_OR:   unitFn = FN_AND;
            default: unitFn = FN_XOR;
          endcase
        end
      endcase
    end
  end

  tr_logic_unit #(.UW(UW), .SLW(SLW)) u_unit (
    .inA        (unitA),
    .inB        (unitB),
    .fn         (unitFn),
    .faultEn    (faultEn),
    .faultSlice (faultSlice),
    .faultVal   (faultVal),
    .y          (unitY)
  );

  // Decoder: inverse of the second-pass encoding
  always_comb begin
    case (modeReg)
      2'b01:   decoded = unitY[WIDTH:1];
      2'b10:   decoded = unitY[WIDTH+1:2];
      default: decoded = (fnReg == FN_XOR) ? unitY[WIDTH-1:0] : ~unitY[WIDTH-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstRes  <= '0;
      secondRes <= '0;
      errFlag   <= 1'b0;
    end else begin
      if (stb.storeFirst)  firstRes  <= unitY[WIDTH-1:0];
      if (stb.storeSecond) secondRes <= decoded;
      if (stb.loadOps)      errFlag <= 1'b0;
      else if (stb.evalCmp) errFlag <= (firstRes != secondRes);
    end
  end

  assign result = firstRes;
  assign error  = errFlag;

  // R3: result only moves when the first pass is stored
  a_r3_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.storeFirst |=> $stable(result));

  // R9: error only moves on a new start or at compare
  a_r9_error_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.loadOps || stb.evalCmp) |=> $stable(error));

  // R9: a sampled start clears error
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadOps |=> !error);

endmodule

// File: rtl/tr_control.sv
module tr_control (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  output tr_pkg::strobe_t stb,
  output logic            done
);
  import tr_pkg::*;

  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (start) stateNext = ST_PASS0;
      ST_PASS0: stateNext = ST_PASS1;
      ST_PASS1: stateNext = ST_CMP;
      ST_CMP:   stateNext = ST_DONE;
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb             = '0;
    stb.loadOps     = (state == ST_IDLE) && start;
    stb.storeFirst  = (state == ST_PASS0);
    stb.encPass     = (state == ST_PASS1);
    stb.storeSecond = (state == ST_PASS1);
    stb.evalCmp     = (state == ST_CMP);
  end

  assign done = (state == ST_DONE);

  // R2: the two passes follow each other with no gap
  a_r2_pass_order: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PASS0) |=> (state == ST_PASS1));

  // R2: compare follows the second pass
  a_r2_cmp_after_pass1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PASS1) |=> (state == ST_CMP));

  // R8: start during a run leaves the sequence alone
  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && state != ST_DONE && start) |=> (state != ST_PASS0));

endmodule

// File: rtl/tr_recompute_checker.sv
module tr_recompute_checker #(
  parameter int WIDTH = 8,
  parameter int SLW   = $clog2(WIDTH + tr_pkg::SHIFT_SPAN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [1:0]       opSel,
  input  logic [1:0]       encMode,
  input  logic             faultEn,
  input  logic [SLW-1:0]   faultSlice,
  input  logic             faultVal,
  output logic             done,
  output logic [WIDTH-1:0] result,
  output logic             error
);
  import tr_pkg::*;

  strobe_t stb;

  tr_control u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stb   (stb),
    .done  (done)
  );

  tr_datapath #(.WIDTH(WIDTH), .SLW(SLW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .opA        (opA),
    .opB        (opB),
    .opSel      (opSel),
    .encMode    (encMode),
    .faultEn    (faultEn),
    .faultSlice (faultSlice),
    .faultVal   (faultVal),
    .result     (result),
    .error      (error)
  );

  // Assertion support: was any fault enabled during the current run
  logic faultSeen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            faultSeen <= 1'b0;
    else if (stb.loadOps) faultSeen <= faultEn;
    else                  faultSeen <= faultSeen | faultEn;
  end

  // R2: done lasts exactly one cycle
  a_r2_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: done only follows the compare step
  a_r2_done_after_cmp: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(stb.evalCmp));

  // R4: a run with no injected fault never flags
  a_r4_clean_no_error: assert property (@(posedge clk) disable iff (!rstN)
    (done && !faultSeen && !faultEn) |-> !error);

endmodule

// File: tb/tb_tr_recompute_checker.sv
module tb_tr_recompute_checker;
  localparam int W   = 8;
  localparam int UW  = W + 2;
  localparam int SLW = $clog2(UW);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] opA = '0, opB = '0;
  logic [1:0] opSel = 2'b00, encMode = 2'b00;
  logic faultEn = 1'b0;
  logic [SLW-1:0] faultSlice = '0;
  logic faultVal = 1'b0;
  logic done, error;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [W-1:0] res;
    logic         err;
    string        tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk; // 50 MHz

  tr_recompute_checker #(.WIDTH(W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
    .opSel(opSel), .encMode(encMode), .faultEn(faultEn),
    .faultSlice(faultSlice), .faultVal(faultVal),
    .done(done), .result(result), .error(error)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural unit with one optional stuck slice
  function automatic logic [UW-1:0] unitM(input logic [UW-1:0] a, input logic [UW-1:0] b,
                                          input logic [1:0] fn, input logic fe,
                                          input logic [SLW-1:0] fs, input logic fv);
    logic [UW-1:0] r;
    r = (fn == 2'b01) ? (a | b) : (fn == 2'b10) ? (a ^ b) : (a & b);
    if (fe && fs < UW) r[fs] = fv;
    return r;
  endfunction

  function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                 input logic [1:0] op, input logic [1:0] md,
                                 input logic fe, input logic [SLW-1:0] fs, input logic fv,
                                 input string tag);
    exp_t e;
    logic [1:0] o, m, dual;
    logic [UW-1:0] y1, y2, ea, eb;
    logic [W-1:0] dec;
    o = (op == 2'b11) ? 2'b00 : op;
    m = (md == 2'b11) ? 2'b00 : md;
    y1 = unitM({2'b00, a}, {2'b00, b}, o, fe, fs, fv);
    if (m == 2'b00) begin
      dual = (o == 2'b00) ? 2'b01 : (o == 2'b01) ? 2'b00 : 2'b10;
      y2 = unitM(~{2'b00, a}, ~{2'b00, b}, dual, fe, fs, fv);
      dec = (o == 2'b10) ? y2[W-1:0] : ~y2[W-1:0];
    end else begin
      ea = {2'b00, a} << m;
      eb = {2'b00, b} << m;
      y2 = unitM(ea, eb, o, fe, fs, fv);
      dec = W'(y2 >> m);
    end
    e.res = y1[W-1:0];
    e.err = (y1[W-1:0] != dec);
    e.tag = tag;
    return e;
  endfunction

  // Driver: one run, with latency and single-pulse checks (R2), optional busy start (R8)
  task automatic runOp(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] op,
                       input logic [1:0] md, input logic fe, input logic [SLW-1:0] fs,
                       input logic fv, input bit holdStart, input string tag);
    exp_t e;
    @(negedge clk);
    opA = a; opB = b; opSel = op; encMode = md;
    faultEn = fe; faultSlice = fs; faultVal = fv;
    start = 1'b1;
    e = model(a, b, op, md, fe, fs, fv, tag);
    sb.push_back(e);
    @(posedge clk);
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      if (holdStart && k < 3) begin
        start = 1'b1; opA = ~a; opB = b ^ 8'h5A; opSel = op + 2'd1; encMode = md + 2'd1;
      end else begin
        start = 1'b0;
      end
      check(done == 1'b0, holdStart ? "R8 early done" : "R2 early done", done, 0);
    end
    @(negedge clk);
    check(done == 1'b1, "R2 done timing", done, 1);
    @(negedge clk);
    check(done == 1'b0, holdStart ? "R8 second done" : "R2 done width", done, 0);
    faultEn = 1'b0;
  endtask

  // Monitor: compares each done against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R2 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(result == e.res, {e.tag, " result"}, result, e.res);
          check(error == e.err, {e.tag, " error"}, error, e.err);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pa [4];
    pa[0] = 8'hA5; pa[1] = 8'h0F; pa[2] = 8'hFF; pa[3] = 8'h81;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(done == 0 && error == 0 && result == 0, "R1 during reset", {done, error, result}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 0 && error == 0 && result == 0, "R1 after release", {done, error, result}, 0);

    // R3, R4: every op code and mode, fault free
    for (int op = 0; op < 4; op++)
      for (int md = 0; md < 4; md++)
        for (int p = 0; p < 3; p++)
          runOp(pa[p], pa[p+1] ^ 8'h3C, 2'(op), 2'(md), 1'b0, '0, 1'b0, 0, "R3 R4 clean");

    // R7: complement mode, AND and OR, every slice below WIDTH stuck at both values
    for (int op = 0; op < 2; op++)
      for (int s = 0; s < W; s++)
        for (int v = 0; v < 2; v++) begin
          runOp(8'hC6, 8'h5B, 2'(op), 2'b00, 1'b1, SLW'(s), 1'(v), 0, "R7 complement detect");
          check(error == 1'b1, "R7 flag raised", error, 1);
        end

    // R5, R6: every slice, value, op, shift mode and a few operand pairs
    for (int md = 0; md < 3; md++)
      for (int op = 0; op < 3; op++)
        for (int s = 0; s < UW + 1; s++)
          for (int v = 0; v < 2; v++)
            runOp(pa[(s + op) % 4], pa[(s + md + 1) % 4] ^ 8'h66, 2'(op), 2'(md),
                  1'b1, SLW'(s), 1'(v), 0, "R5 R6 injected");

    // R8: start held and inputs changed while busy
    runOp(8'h3A, 8'hC5, 2'b10, 2'b01, 1'b0, '0, 1'b0, 1, "R8 busy start");
    runOp(8'hF0, 8'h3C, 2'b00, 2'b00, 1'b1, SLW'(2), 1'b1, 1, "R8 busy start fault");

    // R9: error and result persist, then a new start clears error
    runOp(8'hF0, 8'h0F, 2'b00, 2'b00, 1'b1, SLW'(4), 1'b1, 0, "R9 setup");
    repeat (5) @(negedge clk);
    check(error == 1'b1, "R9 error held", error, 1);
    check(result == 8'h10, "R9 result held", result, 8'h10);
    start = 1'b1; opA = 8'h11; opB = 8'h33; opSel = 2'b01; encMode = 2'b10;
    sb.push_back(model(8'h11, 8'h33, 2'b01, 2'b10, 1'b0, '0, 1'b0, "R9 rerun"));
    @(negedge clk);
    start = 1'b0;
    check(error == 1'b0, "R9 error cleared", error, 0);
    check(result == 8'h10, "R9 result until pass0", result, 8'h10);
    repeat (6) @(negedge clk);
    check(sb.size() == 0, "R2 all runs completed", sb.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule